// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This core counts elapsed time as a day number plus hours, minutes and seconds. It compares that count against a programmed alarm time. A one-second tick input advances the count, but only while the core is switched on through its control register. Every counted tick sets an update flag. A tick that lands the count exactly on the alarm day, hour, minute and second also sets an alarm flag.

Software reaches the core through a 16-bit register port. The port takes a byte offset; the two low offset bits are ignored. Pending flags sit in a status register and are cleared by writing ones. A single registered, active-high interrupt line reports any pending flag whose enable bit is set.

Software loads the time registers one after another. It then reads the time back until two consecutive reads agree. For this reason, a register write always wins over a tick that arrives in the same cycle.

Top module: `rtc_core`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: Register map, by byte offset:

  | Offset | Register | Layout |
  |---|---|---|
  | 0x00 | time hour/minute | hours in bits 15:8, minutes in bits 7:0 |
  | 0x04 | seconds | bits 7:0 |
  | 0x08 | alarm hour/minute | same layout as 0x00 |
  | 0x0C | alarm seconds | bits 7:0 |
  | 0x10 | control | |
  | 0x14 | status | |
  | 0x18 | interrupt enable | |
  | 0x20 | day count | |
  | 0x24 | alarm day | |

  Every other offset reads 0.
- R3: Control bit 7 is the run bit. It reads back as written, and the other control bits read 0. The count holds still while the run bit is 0.
- R4: The count rolls over in a fixed chain:
  - seconds go from 59 to 0 and carry into minutes;
  - minutes go from 59 to 0 and carry into hours;
  - hours go from 23 to 0 and carry into the day count;
  - the day count wraps after 0xFFFF.
- R5: Each tick counted while running sets status bit 4, the update flag.
- R6: Status bit 2, the alarm flag, sets on a counted tick whose new day, hour, minute and second all equal the alarm registers. It sets on no other cycle.
- R7: Writing 1 to status bit 2 or bit 4 clears that flag, and writing 0 leaves it unchanged. If a flag is set and cleared in the same cycle, the set wins.
- R8: `irq` is the OR over all bits of (status AND enable). It is registered, so it follows status and enable by one cycle.
- R9: If a time register (0x00, 0x04 or 0x20) is written in the same cycle as a tick, the written value stands and the tick is dropped. A dropped tick also raises no update flag.
- R10: The enable register keeps only bits 0, 2 and 4, and its other bits read 0. Status bit 0, the stopwatch flag, is never set by this core and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the core with its default parameters: a 16-bit day count, 60 seconds, 60 minutes and 24 hours. Every time field is directly writable. The bench therefore preloads values such as 0xFFFF days at 23:59:59, which puts the full carry chain and the day wrap one tick away instead of days of simulated ticks. The same preloading places the count one second before an alarm, which exposes exact-match detection, the single firing of the alarm, and the set-over-clear race on the status register.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int DAY_W   = 16,
  parameter int SEC_LIM = 60,
  parameter int MIN_LIM = 60,
  parameter int HR_LIM  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [5:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq
);
  localparam logic [3:0] A_HM = 4'd0, A_SEC = 4'd1, A_AHM = 4'd2, A_ASEC = 4'd3,
                         A_CTL = 4'd4, A_ST = 4'd5, A_IE = 4'd6, A_DAY = 4'd8, A_ADAY = 4'd9;
  localparam logic [7:0] SEC_TOP = 8'(SEC_LIM - 1);
  localparam logic [7:0] MIN_TOP = 8'(MIN_LIM - 1);
  localparam logic [7:0] HR_TOP  = 8'(HR_LIM - 1);
  localparam logic [DAY_W-1:0] DAY_ONE = {{(DAY_W-1){1'b0}}, 1'b1};

  logic [7:0] sec, mins, hr, a_sec, a_min, a_hr;
  logic [DAY_W-1:0] day, a_day;
  logic run, st_alm, st_upd, ie_sw, ie_alm, ie_upd;

  wire [3:0] idx = addr[5:2];
  wire unused_ok = &{1'b0, addr[1:0]};

  wire wr_hm  = wr_en && idx == A_HM;
  wire wr_sec = wr_en && idx == A_SEC;
  wire wr_day = wr_en && idx == A_DAY;
  wire wr_st  = wr_en && idx == A_ST;
  wire time_wr = wr_hm || wr_sec || wr_day;
  wire step = tick && run && !time_wr;

  wire s_wrap = sec >= SEC_TOP;
  wire m_wrap = mins >= MIN_TOP;
  wire h_wrap = hr >= HR_TOP;

  wire [7:0] sec_n = s_wrap ? 8'd0 : sec + 8'd1;
  wire [7:0] min_n = !s_wrap ? mins : (m_wrap ? 8'd0 : mins + 8'd1);
  wire [7:0] hr_n  = !(s_wrap && m_wrap) ? hr : (h_wrap ? 8'd0 : hr + 8'd1);
  wire [DAY_W-1:0] day_n = (s_wrap && m_wrap && h_wrap) ? day + DAY_ONE : day;

  wire alarm_hit = step && day_n == a_day && hr_n == a_hr && min_n == a_min && sec_n == a_sec;

  wire [15:0] st_vec = {11'd0, st_upd, 1'b0, st_alm, 2'b00};
  wire [15:0] ie_vec = {11'd0, ie_upd, 1'b0, ie_alm, 1'b0, ie_sw};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= '0; mins <= '0; hr <= '0; day <= '0;
      a_sec <= '0; a_min <= '0; a_hr <= '0; a_day <= '0;
      run <= 1'b0; st_alm <= 1'b0; st_upd <= 1'b0;
      ie_sw <= 1'b0; ie_alm <= 1'b0; ie_upd <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (step) begin
        sec <= sec_n; mins <= min_n; hr <= hr_n; day <= day_n;
      end
      if (wr_hm)  begin hr <= wdata[15:8]; mins <= wdata[7:0]; end
      if (wr_sec) sec <= wdata[7:0];
      if (wr_day) day <= wdata[DAY_W-1:0];
      if (wr_en && idx == A_AHM)  begin a_hr <= wdata[15:8]; a_min <= wdata[7:0]; end
      if (wr_en && idx == A_ASEC) a_sec <= wdata[7:0];
      if (wr_en && idx == A_ADAY) a_day <= wdata[DAY_W-1:0];
      if (wr_en && idx == A_CTL)  run <= wdata[7];
      if (wr_en && idx == A_IE) begin
        ie_sw <= wdata[0]; ie_alm <= wdata[2]; ie_upd <= wdata[4];
      end
      st_alm <= alarm_hit || (st_alm && !(wr_st && wdata[2]));
      st_upd <= step || (st_upd && !(wr_st && wdata[4]));
      irq <= |(st_vec & ie_vec);
    end
  end

  always_comb begin
    case (idx)
      A_HM:    rdata = {hr, mins};
      A_SEC:   rdata = {8'd0, sec};
      A_AHM:   rdata = {a_hr, a_min};
      A_ASEC:  rdata = {8'd0, a_sec};
      A_CTL:   rdata = {8'd0, run, 7'd0};
      A_ST:    rdata = st_vec;
      A_IE:    rdata = ie_vec;
      A_DAY:   rdata = 16'(day);
      A_ADAY:  rdata = 16'(a_day);
      default: rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int DAY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [5:0]       addr,
  input logic [15:0]      wdata,
  input logic             irq,
  input logic             run,
  input logic [7:0]       sec,
  input logic [7:0]       mins,
  input logic [7:0]       hr,
  input logic [DAY_W-1:0] day,
  input logic             st_alm,
  input logic             st_upd,
  input logic             ie_alm,
  input logic             ie_upd
);
  wire twr = wr_en && (addr[5:2] == 4'd0 || addr[5:2] == 4'd1 || addr[5:2] == 4'd8);
  wire pend = (st_alm && ie_alm) || (st_upd && ie_upd);

  p_sec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !twr && sec == 8'd59) |=> sec == 8'd0);

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !twr) |=> ($stable(sec) && $stable(mins) && $stable(hr) && $stable(day)));

  p_alarm_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_alm) |-> $past(tick && run));

  p_w1c_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[5:2] == 4'd5 && wdata[2] && !tick) |=> !st_alm);

  p_irq_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> irq);

  p_irq_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !irq);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[5:2] == 4'd1 && tick) |=> sec == $past(wdata[7:0]));
endmodule

bind rtc_core rtc_core_chk #(.DAY_W(DAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .run(run), .sec(sec), .mins(mins), .hr(hr), .day(day),
  .st_alm(st_alm), .st_upd(st_upd), .ie_alm(ie_alm), .ie_upd(ie_upd)
);

// File: tb/tb_rtc_core.sv
module tb_rtc_core;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_core dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic t = 1'b0);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; tick = t;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin
      rd(6'(i * 4), v); chk("R1 reset reg", v, 16'h0000);
    end
    chk("R1 reset irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_map();
    logic [15:0] v;
    wr(6'h00, 16'h0A1B); rd(6'h00, v); chk("R2 hour/min", v, 16'h0A1B);
    wr(6'h04, 16'h0022); rd(6'h04, v); chk("R2 seconds", v, 16'h0022);
    wr(6'h08, 16'h0C0D); rd(6'h08, v); chk("R2 alarm hm", v, 16'h0C0D);
    wr(6'h0C, 16'h0009); rd(6'h0C, v); chk("R2 alarm sec", v, 16'h0009);
    wr(6'h24, 16'h1234); rd(6'h24, v); chk("R2 alarm day", v, 16'h1234);
    wr(6'h20, 16'h0042); rd(6'h20, v); chk("R2 day", v, 16'h0042);
    rd(6'h1C, v); chk("R2 unmapped", v, 16'h0000);
    wr(6'h10, 16'h00FF); rd(6'h10, v); chk("R3 ctl readback", v, 16'h0080);
    wr(6'h18, 16'hFFFF); rd(6'h18, v); chk("R10 enable mask", v, 16'h0015);
    wr(6'h18, 16'h0000);
    wr(6'h14, 16'hFFFF); rd(6'h14, v); chk("R10 status idle", v, 16'h0000);
  endtask

  task automatic t_stopped();
    logic [15:0] v;
    wr(6'h10, 16'h0000); wr(6'h04, 16'h0005);
    pulse(); rd(6'h04, v); chk("R3 hold when stopped", v, 16'h0005);
    rd(6'h14, v); chk("R3 no flag when stopped", v, 16'h0000);
  endtask

  task automatic t_carry();
    logic [15:0] v;
    wr(6'h10, 16'h0080);
    wr(6'h00, 16'h0305); wr(6'h04, 16'd59); pulse();
    rd(6'h04, v); chk("R4 sec wrap", v, 16'h0000);
    rd(6'h00, v); chk("R4 minute carry", v, 16'h0306);
    wr(6'h20, 16'hFFFF); wr(6'h00, 16'h173B); wr(6'h04, 16'd59); pulse();
    rd(6'h00, v); chk("R4 hour wrap", v, 16'h0000);
    rd(6'h20, v); chk("R4 day wrap", v, 16'h0000);
    pulse(); rd(6'h04, v); chk("R4 plain step", v, 16'h0001);
  endtask

  task automatic t_update();
    logic [15:0] v;
    wr(6'h14, 16'hFFFF); rd(6'h14, v); chk("R7 clear all", v, 16'h0000);
    pulse(); rd(6'h14, v); chk("R5 update flag", v, 16'h0010);
  endtask

  task automatic t_alarm();
    logic [15:0] v;
    wr(6'h24, 16'h0000); wr(6'h08, 16'h0001); wr(6'h0C, 16'h0000);
    wr(6'h20, 16'h0000); wr(6'h00, 16'h0000); wr(6'h04, 16'd59);
    wr(6'h14, 16'h0014);
    pulse(); rd(6'h14, v); chk("R6 alarm match", v, 16'h0014);
    wr(6'h14, 16'h0014); rd(6'h14, v); chk("R7 clear both", v, 16'h0000);
    pulse(); rd(6'h14, v); chk("R6 alarm once", v, 16'h0010);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    wr(6'h14, 16'h0000); rd(6'h14, v); chk("R7 zero keeps", v, 16'h0010);
    wr(6'h14, 16'h0010, 1'b1); rd(6'h14, v); chk("R7 set wins", v, 16'h0010);
    wr(6'h14, 16'h0010); rd(6'h14, v); chk("R7 one clears", v, 16'h0000);
  endtask

  task automatic t_irq();
    wr(6'h18, 16'h0004); pulse(); @(negedge clk);
    chk("R8 masked flag", {15'd0, irq}, 16'h0000);
    wr(6'h14, 16'h0010); wr(6'h18, 16'h0010);
    pulse(); chk("R8 irq lags", {15'd0, irq}, 16'h0000);
    @(negedge clk); chk("R8 irq raised", {15'd0, irq}, 16'h0001);
    wr(6'h18, 16'h0000); chk("R8 irq lags drop", {15'd0, irq}, 16'h0001);
    @(negedge clk); chk("R8 irq dropped", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    wr(6'h00, 16'h0102); wr(6'h04, 16'd10); wr(6'h14, 16'hFFFF);
    wr(6'h04, 16'd20, 1'b1);
    rd(6'h04, v); chk("R9 write wins", v, 16'd20);
    rd(6'h00, v); chk("R9 minutes kept", v, 16'h0102);
    rd(6'h14, v); chk("R9 no update flag", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_map(); t_stopped(); t_carry(); t_update();
    t_alarm(); t_w1c(); t_irq(); t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule